// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block drives synchronous burst reads on an external flash-style memory bus. A host asks for a read with a request, a start address and a device index. The sequencer then issues one address clock with an address-valid strobe and waits the programmed number of device clocks. After that it samples one data word per device clock and hands each word to the host with a one-cycle valid strobe. Up to eight devices hang off the bus. Each has its own active-low chip select, and all of them share one configuration.

The device clock runs at half the system clock. Outputs change on its falling edge, and the device samples on its rising edge. With the gated-clock option the device clock stays low whenever no transfer is under way. The configuration register sets the read latency, the burst length, whether address and data share one bus, and the clock gating. It only accepts a write while the bus is idle. A write made during a transfer is dropped and raises a sticky error flag.

Top module: `burst_rd_seq`

## Requirements
- R1: With latency field L (bits [2:0] of the configuration word, values 0..2 treated as 3), the address occupies device clock 0 and the first word is sampled at the end of device clock L. The host sees the first valid strobe 2L+2 system cycles after the accepting edge.
- R2: The burst length field (bits [5:3]) selects 4, 8, 16, 32 or 1024 words for codes 0, 1, 2, 3 and 4. Codes 5 to 7 select continuous mode. A fixed burst delivers exactly that many words whatever the request does after acceptance.
- R3: In continuous mode the burst ends at the first data clock whose end finds the request low. That clock's word is still delivered. One device clock with every chip select high follows before the block is ready again.
- R4: With the gate bit (bit 7) set, the device clock is held low while the bus is idle and toggles every system cycle during a transfer.
- R5: With the gate bit clear, the device clock toggles on every system cycle.
- R6: The address-valid strobe (active low) is asserted for exactly one device clock (two system cycles) at the start of each burst.
- R7: The busy output is high from acceptance until the end of the trailing deselect clock. Ready is low whenever busy is high, in the same cycle as a configuration write, and, with the clock free-running, whenever the device clock is low.
- R8: A configuration write while busy leaves the configuration unchanged and sets the sticky error flag. A write while idle takes effect for the next burst.
- R9: With the shared-bus bit (bit 6) set, the address appears on the shared bus output with its drive enable high during the address clock, and the separate address lines read zero. With it clear, the separate address lines hold the address from the address clock to the last data clock, and the shared bus is not driven.
- R10: Exactly the chip select named by the device index is low from the address clock through the last data clock. None is low at any other time.
- R11: Each data word is the device bus value at the system edge ending a data clock. It is presented with a valid strobe lasting one system cycle.
- R12: After reset the configuration is latency 4, 4-word bursts, separate buses and free clock. The error flag, busy and valid are low, and all strobes and chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word: gate, shared bus, burst code, latency |
| cfg_err | output | 1 | Sticky flag for a refused configuration write |
| req | input | 1 | Host read request |
| req_addr | input | ADDR_W | Burst start address |
| req_cs | input | CS_W | Device index |
| rdy | output | 1 | Request accepted at an edge where req and rdy are both high |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DATA_W | Read word |
| busy | output | 1 | Bus transaction in progress |
| dev_clk | output | 1 | Device clock |
| dev_cs_n | output | NCS | Active-low chip selects |
| dev_avd_n | output | 1 | Active-low address-valid strobe |
| dev_oe_n | output | 1 | Active-low output enable |
| dev_addr | output | ADDR_W | Separate address lines |
| dev_ad_out | output | DATA_W | Shared bus output value |
| dev_ad_oe | output | 1 | Shared bus drive enable |
| dev_rdata | input | DATA_W | Device data bus input |

## Verification
Every state change happens on a system edge, and ready is combinational from the state, the clock phase and the write strobe. The address strobe, chip selects and busy follow the accepting edge one cycle later. Each read word lands in the cycle after the edge that ends its data clock, so the first one arrives 2L+2 cycles after acceptance. The bench's model advances on the same edges and is compared against every output at the falling system edge, well away from the edge where stimulus changes. Directed checks then measure the first-word delay, the word count per burst and the error flag.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef struct packed {
        logic       gate;
        logic       shared;
        logic [2:0] blen;
        logic [2:0] lat;
    } brs_cfg_t;

    localparam int WCNT_W = 11;
    localparam brs_cfg_t CFG_RESET = '{gate: 1'b0, shared: 1'b0, blen: 3'd0, lat: 3'd4};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_DATA,
        ST_GAP
    } brs_state_e;

    function automatic logic is_cont(input logic [2:0] code);
        return code > 3'd4;
    endfunction

    function automatic logic [WCNT_W-1:0] burst_words(input logic [2:0] code);
        case (code)
            3'd0:    return WCNT_W'(4);
            3'd1:    return WCNT_W'(8);
            3'd2:    return WCNT_W'(16);
            3'd3:    return WCNT_W'(32);
            3'd4:    return WCNT_W'(1024);
            default: return '0;
        endcase
    endfunction

    function automatic logic [2:0] eff_lat(input logic [2:0] lat);
        return (lat < 3'd3) ? 3'd3 : lat;
    endfunction

endpackage

// File: rtl/brs_clkgen.sv
module brs_clkgen (
    input  logic clk,
    input  logic rst,
    input  logic gate_en,
    input  logic busy,
    output logic ph,
    output logic ph_nxt
);
    logic run;

    assign run    = !gate_en || busy;
    assign ph_nxt = run ? !ph : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else     ph <= ph_nxt;
    end

    // R4
    gated_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !busy && $past(gate_en && !busy)) |-> !ph);

    // R5
    free_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate_en && $past(!gate_en) && !$past(rst)) |-> (ph != $past(ph)));

endmodule

// File: rtl/brs_cfg.sv
module brs_cfg
    import brs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  logic [7:0] wdata,
    input  logic     busy,
    output brs_cfg_t cfg,
    output logic     err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
            err <= 1'b0;
        end else if (we) begin
            if (busy) err <= 1'b1;
            else      cfg <= brs_cfg_t'(wdata);
        end
    end

    // R8
    refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && busy) |=> (cfg == $past(cfg)));

    // R8
    refused_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (we && busy) |=> err);

endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
    import brs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int NCS    = 8,
    localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  brs_cfg_t          cfg,
    input  logic              tick,
    input  logic              ph_nxt,
    input  logic              cfg_we,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              rdy,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCS-1:0]    dev_cs_n,
    output logic              dev_avd_n,
    output logic              dev_oe_n,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_ad_out,
    output logic              dev_ad_oe
);
    brs_state_e          state;
    logic [ADDR_W-1:0]   addr_q;
    logic [CS_W-1:0]     cs_q;
    logic [2:0]          lat_left;
    logic [WCNT_W-1:0]   wcnt;
    logic                last_word;
    logic                selected;

    assign busy      = (state != ST_IDLE);
    assign rdy       = (state == ST_IDLE) && !ph_nxt && !cfg_we;
    assign last_word = is_cont(cfg.blen) ? !req
                                         : ((wcnt + WCNT_W'(1)) == burst_words(cfg.blen));
    assign selected  = (state == ST_ADDR) || (state == ST_WAIT) || (state == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            cs_q     <= '0;
            lat_left <= '0;
            wcnt     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req && rdy) begin
                    state  <= ST_ADDR;
                    addr_q <= req_addr;
                    cs_q   <= req_cs;
                end
                ST_ADDR: if (tick) begin
                    state    <= ST_WAIT;
                    lat_left <= eff_lat(cfg.lat) - 3'd1;
                end
                ST_WAIT: if (tick) begin
                    if (lat_left == 3'd1) begin
                        state <= ST_DATA;
                        wcnt  <= '0;
                    end else begin
                        lat_left <= lat_left - 3'd1;
                    end
                end
                ST_DATA: if (tick) begin
                    rd_valid <= 1'b1;
                    rd_data  <= dev_rdata;
                    wcnt     <= wcnt + WCNT_W'(1);
                    if (last_word) state <= ST_GAP;
                end
                ST_GAP: if (tick) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign dev_cs_n[g] = !(selected && (cs_q == CS_W'(g)));
    end

    assign dev_avd_n  = (state != ST_ADDR);
    assign dev_oe_n   = !((state == ST_WAIT) || (state == ST_DATA));
    assign dev_ad_oe  = cfg.shared && (state == ST_ADDR);
    assign dev_ad_out = dev_ad_oe ? DATA_W'(addr_q) : '0;
    assign dev_addr   = (!cfg.shared && selected) ? addr_q : '0;

    // R6
    avd_two_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_avd_n) |=> !dev_avd_n);

    // R6
    avd_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (!dev_avd_n && $past(!dev_avd_n)) |=> dev_avd_n);

    // R10
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dev_cs_n));

    // R11
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R7
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rdy);

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import brs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int NCS    = 8,
    localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic              cfg_err,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    output logic              rdy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              dev_clk,
    output logic [NCS-1:0]    dev_cs_n,
    output logic              dev_avd_n,
    output logic              dev_oe_n,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_ad_out,
    output logic              dev_ad_oe,
    input  logic [DATA_W-1:0] dev_rdata
);
    brs_cfg_t cfg;
    logic     ph;
    logic     ph_nxt;

    brs_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .busy  (busy),
        .cfg   (cfg),
        .err   (cfg_err)
    );

    brs_clkgen u_clk (
        .clk     (clk),
        .rst     (rst),
        .gate_en (cfg.gate),
        .busy    (busy),
        .ph      (ph),
        .ph_nxt  (ph_nxt)
    );

    brs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCS(NCS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .tick       (ph),
        .ph_nxt     (ph_nxt),
        .cfg_we     (cfg_we),
        .req        (req),
        .req_addr   (req_addr),
        .req_cs     (req_cs),
        .dev_rdata  (dev_rdata),
        .rdy        (rdy),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .dev_cs_n   (dev_cs_n),
        .dev_avd_n  (dev_avd_n),
        .dev_oe_n   (dev_oe_n),
        .dev_addr   (dev_addr),
        .dev_ad_out (dev_ad_out),
        .dev_ad_oe  (dev_ad_oe)
    );

    assign dev_clk = ph;

endmodule

// File: tb/test_burst_rd_seq.sv
module test_burst_rd_seq;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NC = 8;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic cfg_err;
    logic req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_cs = '0;
    logic rdy, rd_valid, busy, dev_clk, dev_avd_n, dev_oe_n, dev_ad_oe;
    logic [DW-1:0] rd_data, dev_ad_out;
    logic [NC-1:0] dev_cs_n;
    logic [AW-1:0] dev_addr;
    logic [DW-1:0] dev_rdata = 16'h0101;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    burst_rd_seq #(.ADDR_W(AW), .DATA_W(DW), .NCS(NC)) i_burst_rd_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .req(req), .req_addr(req_addr), .req_cs(req_cs), .rdy(rdy),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .dev_clk(dev_clk),
        .dev_cs_n(dev_cs_n), .dev_avd_n(dev_avd_n), .dev_oe_n(dev_oe_n),
        .dev_addr(dev_addr), .dev_ad_out(dev_ad_out), .dev_ad_oe(dev_ad_oe),
        .dev_rdata(dev_rdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        #1 dev_rdata <= dev_rdata + 16'h1357;
    end

    // reference model: modes 0 idle, 1 address, 2 latency wait, 3 data, 4 deselect
    int m_mode, m_ph, m_left, m_cnt, m_lat, m_blen, m_mux, m_gce, m_err, m_vld, m_acc, m_cs;
    logic [DW-1:0] m_data;
    logic [AW-1:0] m_addr;

    function automatic int words_of(int code);
        if (code <= 3) return 4 << code;
        if (code == 4) return 1024;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_ph = 0; m_left = 0; m_cnt = 0; m_lat = 4; m_blen = 0;
            m_mux = 0; m_gce = 0; m_err = 0; m_vld = 0; m_acc = 0; m_cs = 0;
            m_data = '0; m_addr = '0;
        end else begin
            int tick, phn, mode;
            tick = m_ph;
            phn  = (m_gce == 0 || m_mode != 0) ? 1 - m_ph : 0;
            mode = m_mode;
            m_vld = 0; m_acc = 0;
            if (cfg_we) begin
                if (mode != 0) m_err = 1;
                else begin
                    m_lat = (cfg_wdata[2:0] < 3) ? 3 : int'(cfg_wdata[2:0]);
                    m_blen = int'(cfg_wdata[5:3]);
                    m_mux = int'(cfg_wdata[6]);
                    m_gce = int'(cfg_wdata[7]);
                end
            end
            case (mode)
                0: if (req && phn == 0 && !cfg_we) begin
                    m_mode = 1; m_addr = req_addr; m_cs = int'(req_cs); m_acc = 1;
                end
                1: if (tick != 0) begin m_mode = 2; m_left = m_lat - 1; end
                2: if (tick != 0) begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin m_mode = 3; m_cnt = 0; end
                end
                3: if (tick != 0) begin
                    m_vld = 1; m_data = dev_rdata; m_cnt = m_cnt + 1;
                    if (m_blen > 4 ? !req : (m_cnt == words_of(m_blen))) m_mode = 4;
                end
                default: if (tick != 0) m_mode = 0;
            endcase
            m_ph = phn;
        end
    end

    task automatic chk(input string r, input string sig, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", r, sig, got, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            logic sel;
            logic [NC-1:0] cs_exp;
            sel = (m_mode >= 1 && m_mode <= 3);
            cs_exp = sel ? ~(NC'(1) << m_cs) : '1;
            chk("R4", "dev_clk", 32'(dev_clk), 32'(m_ph));
            chk("R6", "dev_avd_n", 32'(dev_avd_n), 32'(m_mode != 1));
            chk("R10", "dev_cs_n", 32'(dev_cs_n), 32'(cs_exp));
            chk("R7", "busy", 32'(busy), 32'(m_mode != 0));
            chk("R7", "rdy", 32'(rdy), 32'(m_mode == 0 && (m_gce != 0 || m_ph == 1) && !cfg_we));
            chk("R11", "rd_valid", 32'(rd_valid), 32'(m_vld));
            chk("R11", "rd_data", 32'(rd_data), 32'(m_data));
            chk("R1", "dev_oe_n", 32'(dev_oe_n), 32'(!(m_mode == 2 || m_mode == 3)));
            chk("R9", "dev_ad_oe", 32'(dev_ad_oe), 32'(m_mux != 0 && m_mode == 1));
            chk("R9", "dev_ad_out", 32'(dev_ad_out), (m_mux != 0 && m_mode == 1) ? 32'(m_addr) : 32'd0);
            chk("R9", "dev_addr", 32'(dev_addr), (m_mux == 0 && sel) ? 32'(m_addr) : 32'd0);
            chk("R8", "cfg_err", 32'(cfg_err), 32'(m_err));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cfg_write(input logic [7:0] v);
        @(posedge clk); #1 cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1 cfg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_mode != 0) begin @(posedge clk); #1; end
    endtask

    // fixed burst: measure first-word delay and word count
    task automatic burst(input logic [AW-1:0] a, input int cs, input int lat, input int words);
        int d, nv;
        wait_idle();
        @(posedge clk); #1 req = 1'b1; req_addr = a; req_cs = CW'(cs);
        do begin @(posedge clk); #1; end while (m_acc == 0);
        req = 1'b0;
        d = 0;
        do begin @(posedge clk); #1; d++; end while (!rd_valid && d < 40);
        chk("R1", "first word delay", 32'(d), 32'(2 * lat + 2));
        nv = 1;
        while (busy) begin @(posedge clk); #1; if (rd_valid) nv++; end
        chk("R2", "word count", 32'(nv), 32'(words));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R12", "reset busy", 32'(busy), 0);
        chk("R12", "reset cs", 32'(dev_cs_n), 32'hFF);
        chk("R12", "reset avd/oe/valid", {dev_avd_n, dev_oe_n, rd_valid, cfg_err}, 32'b1100);

        burst(16'h1234, 2, 4, 4);                   // reset config
        cfg_write(8'b1_1_001_011);                   // gated, shared, 8 words, lat 3
        repeat (5) @(negedge clk);
        chk("R4", "gated idle clk", 32'(dev_clk), 0);
        burst(16'hA5C3, 7, 3, 8);
        cfg_write(8'b0_0_010_111);                   // lat 7, 16 words
        burst(16'h0F0F, 0, 7, 16);
        cfg_write(8'b1_0_011_001);                   // lat 1 -> 3, 32 words
        burst(16'h7777, 5, 3, 32);

        // refused write mid-burst
        wait_idle();
        @(posedge clk); #1 req = 1'b1; req_addr = 16'h4444; req_cs = 3'd1;
        do begin @(posedge clk); #1; end while (m_acc == 0);
        req = 1'b0;
        cfg_write(8'b0_1_000_110);
        chk("R8", "sticky error", 32'(cfg_err), 1);
        wait_idle();
        burst(16'h5555, 3, 3, 32);                   // config unchanged

        cfg_write(8'b0_1_100_101);                   // 1024 words, lat 5
        burst(16'hBEEF, 6, 5, 1024);

        // continuous: drop request after 10 words
        cfg_write(8'b1_0_111_100);
        wait_idle();
        @(posedge clk); #1 req = 1'b1; req_addr = 16'hC0DE; req_cs = 3'd4;
        begin
            int nv;
            nv = 0;
            do begin @(posedge clk); #1; if (rd_valid) nv++; end while (nv < 10);
            req = 1'b0;
            while (busy) begin @(posedge clk); #1; if (rd_valid) nv++; end
            chk("R3", "continuous words", 32'(nv), 11);
        end
        repeat (4) @(negedge clk);
        chk("R4", "gated idle after cont", 32'(dev_clk), 0);
        chk("R8", "error still set", 32'(cfg_err), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule